// File: doc/BRIEF.md
# Mixer Enable Admission Controller

A bank of digital mixer paths shares a fixed number of system clock cycles in each sample period. Every mixer always blends four inputs, each with its own gain, so its cycle cost is four times a programmable per-input cost. That product is then divided by the mixer's rate code, because a slower path needs fewer cycles per period. This controller decides which enable requests may go ahead. It keeps a running total of the cycles that the enabled mixers have committed. It admits an enable only when the new total still fits the programmed budget.

Software raises enable or disable requests through per-mixer strobes. These requests are latched and then served one per clock, lowest mixer index first. An enable that would exceed the budget is refused. A refusal leaves every running mixer and the committed total exactly as they were, and it sets a sticky underclock flag. That flag drives a status pin directly and an interrupt line through an enable mask. The per-mixer status vector shows which enables actually took effect, so software can work out which requests failed after an error.

Top module: `mixadm_top`

## Requirements
- R1: After a synchronous reset, all mixer status bits are 0, the committed total is 0, and the underclock flag and interrupt are 0.
- R2: The cost of an enable is (per-input cost × 4) shifted right by the mixer's 2-bit rate code (codes 0..3 divide by 1, 2, 4, 8). The rate code is sampled when the request is served.
- R3: An enable of an off mixer is granted exactly when committed + cost ≤ budget, equality included. On a grant the status bit is set and the committed total grows by the cost.
- R4: A refused enable leaves every status bit and the committed total unchanged and sets the underclock flag.
- R5: A disable of an on mixer clears its status bit and subtracts the cost committed at its grant, even if its rate code has changed since then.
- R6: Enabling an on mixer or disabling an off mixer changes nothing and raises no error.
- R7: A request strobed before clock edge k shows its result after edge k+1. Requests strobed together are served one per cycle in ascending index order.
- R8: The underclock flag stays set until an error-clear pulse. If a refusal and a clear fall in the same cycle, the flag ends set.
- R9: The interrupt equals the underclock flag ANDed with the interrupt enable. The error pin output carries the flag whatever the mask is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| budget_i | input | CYC_W | Cycles available per sample period |
| unit_cost_i | input | COST_W | Cycle cost of one mixer input |
| rate_code_i | input | N_MIX*2 | Per-mixer rate code, mixer i at bits [2i+1:2i] |
| req_stb_i | input | N_MIX | One-cycle request strobe per mixer |
| req_on_i | input | N_MIX | Requested state per mixer (1 enable, 0 disable) |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the underclock flag |
| irq_en_i | input | 1 | Interrupt enable mask |
| mix_on_o | output | N_MIX | Status bit per mixer: enabled |
| committed_o | output | CYC_W | Cycles committed by enabled mixers |
| err_pin_o | output | 1 | Sticky underclock flag, unmasked, for a status pin |
| irq_o | output | 1 | Masked underclock interrupt |

## Verification
The bench builds the block with six mixers, a 12-bit budget and an 8-bit per-input cost. With these values a handful of enables fills the budget, so grants, refusals and exact-fit grants all occur often under random traffic. Directed cases use a cost of 10 per input and a budget of 100. The exact-fit boundary, ascending service order with a refusal in third place, a rate change between a grant and its release, and a refusal that coincides with a clear are then each reached in a few requests.

// File: rtl/mixadm_pkg.sv
package mixadm_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_GRANT,
    ACT_REFUSE,
    ACT_RELEASE,
    ACT_NOP
  } act_e;

  localparam int RATE_W = 2;
  localparam int INPUTS_PER_MIX_LOG2 = 2;

endpackage

// File: rtl/mixadm_pick.sv
module mixadm_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
      end
    end
    oh_o = vld_o ? (N'(1) << idx_o) : '0;
  end

  // R7: nothing below the chosen index may still be pending
  always_comb begin
    if (vld_o) begin
      p_lowest_first_r7: assert ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0);
    end
  end

endmodule

// File: rtl/mixadm_cost.sv
module mixadm_cost
  import mixadm_pkg::*;
#(
  parameter int N      = 8,
  parameter int COST_W = 8,
  parameter int IW     = (N > 1) ? $clog2(N) : 1,
  parameter int CW     = COST_W + INPUTS_PER_MIX_LOG2
) (
  input  logic [COST_W-1:0]   unit_cost_i,
  input  logic [N*RATE_W-1:0] rate_code_i,
  input  logic [IW-1:0]       idx_i,
  output logic [CW-1:0]       cost_o
);

  logic [RATE_W-1:0] rate_vec [N];

  for (genvar g = 0; g < N; g++) begin : g_rate
    assign rate_vec[g] = rate_code_i[g*RATE_W +: RATE_W];
  end

  logic [CW-1:0] full_cost;
  assign full_cost = {unit_cost_i, {INPUTS_PER_MIX_LOG2{1'b0}}};
  assign cost_o    = full_cost >> rate_vec[idx_i];

endmodule

// File: rtl/mixadm_ledger.sv
module mixadm_ledger #(
  parameter int N  = 8,
  parameter int CW = 10,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [CW-1:0] rdata_o
);

  logic [CW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/mixadm_top.sv
module mixadm_top
  import mixadm_pkg::*;
#(
  parameter int N_MIX  = 8,
  parameter int CYC_W  = 16,
  parameter int COST_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CYC_W-1:0]        budget_i,
  input  logic [COST_W-1:0]       unit_cost_i,
  input  logic [N_MIX*RATE_W-1:0] rate_code_i,
  input  logic [N_MIX-1:0]        req_stb_i,
  input  logic [N_MIX-1:0]        req_on_i,
  input  logic                    err_clr_i,
  input  logic                    irq_en_i,
  output logic [N_MIX-1:0]        mix_on_o,
  output logic [CYC_W-1:0]        committed_o,
  output logic                    err_pin_o,
  output logic                    irq_o
);

  localparam int IW = (N_MIX > 1) ? $clog2(N_MIX) : 1;
  localparam int CW = COST_W + INPUTS_PER_MIX_LOG2;
  localparam int SW = CYC_W + 2;

  logic [N_MIX-1:0] pend_q, dir_q, on_q;
  logic [CYC_W-1:0] acc_q;
  logic             err_q, irq_q;

  logic             sel_vld;
  logic [IW-1:0]    sel_idx;
  logic [N_MIX-1:0] sel_oh;
  logic [CW-1:0]    sel_cost, held_cost;
  logic [SW-1:0]    trial_sum;
  logic             fits;
  act_e             act;
  logic             err_d;

  mixadm_pick #(.N(N_MIX), .IW(IW)) u_pick (
    .pend_i (pend_q),
    .vld_o  (sel_vld),
    .idx_o  (sel_idx),
    .oh_o   (sel_oh)
  );

  mixadm_cost #(.N(N_MIX), .COST_W(COST_W), .IW(IW), .CW(CW)) u_cost (
    .unit_cost_i (unit_cost_i),
    .rate_code_i (rate_code_i),
    .idx_i       (sel_idx),
    .cost_o      (sel_cost)
  );

  mixadm_ledger #(.N(N_MIX), .CW(CW), .IW(IW)) u_ledger (
    .clk     (clk),
    .we_i    (act == ACT_GRANT),
    .waddr_i (sel_idx),
    .wdata_i (sel_cost),
    .raddr_i (sel_idx),
    .rdata_o (held_cost)
  );

  assign trial_sum = {2'b00, acc_q} + SW'(sel_cost);
  assign fits      = trial_sum <= {2'b00, budget_i};

  always_comb begin
    if (!sel_vld)                       act = ACT_IDLE;
    else if (dir_q[sel_idx] == on_q[sel_idx]) act = ACT_NOP;
    else if (!dir_q[sel_idx])           act = ACT_RELEASE;
    else if (fits)                      act = ACT_GRANT;
    else                                act = ACT_REFUSE;
  end

  assign err_d = (act == ACT_REFUSE) | (err_q & ~err_clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      dir_q  <= '0;
      on_q   <= '0;
      acc_q  <= '0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~sel_oh) | req_stb_i;
      dir_q  <= (dir_q & ~req_stb_i) | (req_on_i & req_stb_i);
      unique case (act)
        ACT_GRANT: begin
          on_q[sel_idx] <= 1'b1;
          acc_q         <= trial_sum[CYC_W-1:0];
        end
        ACT_RELEASE: begin
          on_q[sel_idx] <= 1'b0;
          acc_q         <= acc_q - CYC_W'(held_cost);
        end
        default: ;
      endcase
      err_q <= err_d;
      irq_q <= err_d & irq_en_i;
    end
  end

  assign mix_on_o    = on_q;
  assign committed_o = acc_q;
  assign err_pin_o   = err_q;
  assign irq_o       = irq_q;

  // R7: at most one mixer served per cycle
  p_one_served_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_oh));

  // R3: a grant never leaves the total above the budget it was checked against
  p_grant_in_budget_r3: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_GRANT) |=> (acc_q <= $past(budget_i)));

  // R4: a refusal disturbs no running mixer and raises the flag
  p_refuse_atomic_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_REFUSE) |=> ($stable(on_q) && $stable(acc_q) && err_q));

  // R6: redundant requests leave status and total alone
  p_nop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_NOP) |=> ($stable(on_q) && $stable(acc_q)));

  // R8: flag holds without a clear
  p_sticky_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr_i) |=> err_q);

  // R9: interrupt implies the flag
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> err_pin_o);

endmodule

// File: tb/mixadm_top_tb.sv
`timescale 1ns/1ps
module mixadm_top_tb;

  localparam int N = 6;
  localparam int CYC_W = 12;
  localparam int COST_W = 8;

  logic clk = 1'b0;
  logic rst;
  logic [CYC_W-1:0]  budget;
  logic [COST_W-1:0] ucost;
  logic [N*2-1:0]    rate_code;
  logic [N-1:0]      req_stb, req_on;
  logic              err_clr, irq_en;
  logic [N-1:0]      mix_on;
  logic [CYC_W-1:0]  committed;
  logic              err_pin, irq;

  logic [1:0] rate_m [N];
  bit  m_on [N];
  int  m_cost [N];
  int  m_acc;
  bit  m_err;
  int  total = 0, bad = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) rate_code[i*2 +: 2] = rate_m[i];
  end

  mixadm_top #(.N_MIX(N), .CYC_W(CYC_W), .COST_W(COST_W)) u_dut (
    .clk(clk), .rst(rst), .budget_i(budget), .unit_cost_i(ucost),
    .rate_code_i(rate_code), .req_stb_i(req_stb), .req_on_i(req_on),
    .err_clr_i(err_clr), .irq_en_i(irq_en), .mix_on_o(mix_on),
    .committed_o(committed), .err_pin_o(err_pin), .irq_o(irq)
  );

  function automatic int cost_f(int c, int r);
    return (c * 4) >> r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = m_on[i];
    check(tag, "mix_on", int'(mix_on), int'(e));
    check(tag, "committed", int'(committed), m_acc);
    check(tag, "err_pin", int'(err_pin), int'(m_err));
    check(tag, "irq", int'(irq), int'(m_err & irq_en));
  endtask

  task automatic model_serve(int idx, bit en);
    if (en && !m_on[idx]) begin
      int c = cost_f(int'(ucost), int'(rate_m[idx]));
      if (m_acc + c <= int'(budget)) begin
        m_on[idx] = 1; m_cost[idx] = c; m_acc += c;
      end else m_err = 1;
    end else if (!en && m_on[idx]) begin
      m_on[idx] = 0; m_acc -= m_cost[idx];
    end
  endtask

  task automatic do_req(int idx, bit en, int rt, bit clr_same);
    bit was_err;
    @(negedge clk);
    rate_m[idx] = 2'(rt);
    req_stb = N'(1) << idx;
    req_on  = en ? (N'(1) << idx) : '0;
    @(negedge clk);
    req_stb = '0;
    err_clr = clr_same;
    @(negedge clk);
    err_clr = 1'b0;
    was_err = m_err;
    if (clr_same) m_err = 0;
    model_serve(idx, en);
    if (clr_same && !m_err) m_err = 0;
    if (!clr_same) m_err = m_err | was_err;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_err = 0;
    check("R8", "flag after clear", int'(err_pin), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst = 1'b1; req_stb = '0; req_on = '0; err_clr = 1'b0; irq_en = 1'b1;
    budget = 12'd100; ucost = 8'd10;
    for (int i = 0; i < N; i++) begin rate_m[i] = 2'd0; m_on[i] = 0; m_cost[i] = 0; end
    m_acc = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all("R1");

    // R2 / R3: costs 40, 20, then an exact fit of 40 reaching 100
    do_req(0, 1, 0, 0); compare_all("R2");
    do_req(1, 1, 1, 0); compare_all("R2");
    do_req(2, 1, 0, 0); compare_all("R3");
    check("R3", "exact fit total", int'(committed), 100);
    // R4: cost 5 on a full budget is refused
    do_req(3, 1, 3, 0); compare_all("R4");
    check("R4", "flag raised", int'(err_pin), 1);
    // R8: flag persists across idle cycles
    repeat (4) @(negedge clk);
    check("R8", "flag held", int'(err_pin), 1);
    clear_err();
    // R6: redundant enable and redundant disable
    do_req(0, 1, 2, 0); compare_all("R6");
    do_req(4, 0, 0, 0); compare_all("R6");
    // R9: masked interrupt with a refusal
    irq_en = 1'b0;
    do_req(5, 1, 0, 0); compare_all("R9");
    check("R9", "pin unmasked", int'(err_pin), 1);
    check("R9", "irq masked", int'(irq), 0);
    irq_en = 1'b1;
    clear_err();
    // R8: refusal in the same cycle as a clear leaves the flag set
    do_req(5, 1, 0, 1); compare_all("R8");
    check("R8", "set beats clear", int'(err_pin), 1);
    clear_err();
    // R5: rate code changes after grant; release uses committed cost 20
    do_req(1, 0, 3, 0); compare_all("R5");
    check("R5", "total after release", int'(committed), 80);
    do_req(0, 0, 0, 0); compare_all("R5");
    do_req(2, 0, 0, 0); compare_all("R5");
    // R7: three enables together, cost 40 each, budget 100
    @(negedge clk);
    for (int i = 0; i < N; i++) rate_m[i] = 2'd0;
    req_stb = 6'b101010; req_on = 6'b101010;
    @(negedge clk); req_stb = '0; req_on = '0;
    @(negedge clk);
    check("R7", "first served index 1", int'(mix_on), 6'b000010);
    check("R7", "total after first", int'(committed), 40);
    @(negedge clk);
    check("R7", "second served index 3", int'(mix_on), 6'b001010);
    @(negedge clk);
    check("R7", "index 5 refused last", int'(mix_on), 6'b001010);
    check("R7", "flag after third", int'(err_pin), 1);
    m_on[1] = 1; m_on[3] = 1; m_cost[1] = 40; m_cost[3] = 40; m_acc = 80; m_err = 1;
    compare_all("R7");
    clear_err();

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int idx = int'($urandom_range(N - 1));
      bit en  = ($urandom_range(9) < 6);
      int rt  = int'($urandom_range(3));
      if ($urandom_range(7) == 0) budget = 12'($urandom_range(400, 50));
      ucost  = 8'($urandom_range(40, 1));
      irq_en = 1'($urandom_range(1));
      do_req(idx, en, rt, 0);
      compare_all("R2/R3/R4/R5/R6");
      if ($urandom_range(5) == 0) clear_err();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule